// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write an external 128K x 8 asynchronous static RAM. A single request port with valid/ready handshaking carries an address, a write flag and write data. The controller then plays out the pin sequence the memory needs. It drives the address, an active-low and an active-high chip select, an active-low output enable and an active-low write enable. The bidirectional data bus is split into a drive value, a drive enable and a sampled input. A read returns its byte on `rd_data` with a one-cycle `rd_valid` pulse.

Every interval is derived from nanosecond speed-grade parameters and the clock period. Each limit is rounded up to whole cycles: write pulse, data setup, chip-select-to-end-of-write, address-to-end-of-write, cycle time, access time and output float time. The block accepts no new request until the whole cycle, including any bus turnaround, has elapsed.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sram_cs_n`=1, `sram_cs`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0, `rd_valid`=0 and `req_ready`=1.
- R2: The two chip selects always move together (`sram_cs_n` == !`sram_cs`). Whenever `req_ready` is high, the memory is deselected and the data bus is not driven.
- R3: A write drives address, data and both chip selects for one cycle with `sram_we_n` high. It then holds `sram_we_n` low for WPL consecutive cycles, where WPL = max(ceil(T_WP/CLK), ceil(T_DW/CLK), ceil(T_CW/CLK)-1, ceil(T_AW/CLK)-1, 1).
- R4: `sram_we_n` returns high one cycle before the data drive and chip selects are released. Address and write data stay unchanged while `sram_we_n` is low, and the byte written is the one later read back from that address.
- R5: After a write is accepted, `req_ready` stays low for max(WPL+2, ceil(T_WC/CLK)) cycles.
- R6: A read releases the bus and asserts both chip selects and `sram_oe_n` for ACC cycles, where ACC = max(ceil(T_AA/CLK), ceil(T_CO/CLK), ceil(T_OE/CLK)). It then samples `sram_dq_in`, and `rd_valid` is high for exactly one cycle, ACC+1 cycles after acceptance, carrying that byte.
- R7: After a read, output enable and chip selects are deasserted, and `req_ready` stays low for RT = max(ceil(T_HZ/CLK), ceil(T_RC/CLK)-ACC, 1) more cycles. A following write therefore never drives the bus inside the memory's output float window.
- R8: `sram_oe_n` and `sram_we_n` are never low together, and `sram_dq_oe` is never high while `sram_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 8 | Read byte |
| sram_addr | output | 17 | Memory address pins |
| sram_cs_n | output | 1 | Active-low chip select |
| sram_cs | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_dq_out | output | 8 | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The bench builds the controller with a 20 ns clock and stretches both the write and read cycle-time limits to 140 ns. This makes the padding phase after a write and the cycle-time-bound read tail both non-zero, so every branch of the sequencer runs. With these settings WPL is 3, ACC is 4 and both busy windows are 7 cycles. A behavioural memory in the bench measures pulse width, setup, access time and float-window conflicts in nanoseconds on the pins. The 70 ns access check therefore has no slack left at a 20 ns period.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_WPAD, ST_RACC, ST_RTAIL
  } seq_st_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned less1(input int unsigned a);
    return (a > 0) ? a - 1 : 0;
  endfunction

  // write-enable low cycles: pulse, data setup, select/address to end of write
  function automatic int unsigned wr_pulse(input int unsigned wp, input int unsigned dw,
                                           input int unsigned cw, input int unsigned aw,
                                           input int unsigned clk_ns);
    int unsigned r;
    r = imax(ns2cyc(wp, clk_ns), ns2cyc(dw, clk_ns));
    r = imax(r, less1(ns2cyc(cw, clk_ns)));
    r = imax(r, less1(ns2cyc(aw, clk_ns)));
    return imax(r, 1);
  endfunction

  // idle cycles appended so a write occupies at least the write cycle time
  function automatic int unsigned wr_pad(input int unsigned wc, input int unsigned wpl,
                                         input int unsigned clk_ns);
    int unsigned c;
    c = ns2cyc(wc, clk_ns);
    return (c > wpl + 2) ? c - (wpl + 2) : 0;
  endfunction

  function automatic int unsigned rd_access(input int unsigned aa, input int unsigned co,
                                            input int unsigned oe, input int unsigned clk_ns);
    return imax(imax(imax(ns2cyc(aa, clk_ns), ns2cyc(co, clk_ns)), ns2cyc(oe, clk_ns)), 1);
  endfunction

  // cycles after a read: output float time, then remaining read cycle time
  function automatic int unsigned rd_tail(input int unsigned hz, input int unsigned rc,
                                          input int unsigned acc, input int unsigned clk_ns);
    int unsigned c;
    c = ns2cyc(rc, clk_ns);
    return imax(imax(ns2cyc(hz, clk_ns), (c > acc) ? c - acc : 0), 1);
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned WPL   = 5,
  parameter int unsigned WPAD  = 0,
  parameter int unsigned ACC   = 7,
  parameter int unsigned RT    = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  output logic idle,
  output logic sel,
  output logic oe_act,
  output logic we_act,
  output logic drv,
  output logic capture
);
  localparam bit HAS_PAD = (WPAD > 0);
  localparam logic [CNT_W-1:0] LD_WPL = CNT_W'(WPL - 1);
  localparam logic [CNT_W-1:0] LD_PAD = CNT_W'(less1(WPAD));
  localparam logic [CNT_W-1:0] LD_ACC = CNT_W'(ACC - 1);
  localparam logic [CNT_W-1:0] LD_RT  = CNT_W'(RT - 1);

  seq_st_e          st_q, st_d;
  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_val;

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  always_comb begin
    st_d    = st_q;
    t_load  = 1'b0;
    t_val   = '0;
    capture = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        if (start_wr) st_d = ST_WSETUP;
        else begin
          st_d = ST_RACC; t_load = 1'b1; t_val = LD_ACC;
        end
      end
      ST_WSETUP: begin st_d = ST_WPULSE; t_load = 1'b1; t_val = LD_WPL; end
      ST_WPULSE: if (t_zero) st_d = ST_WHOLD;
      ST_WHOLD: begin
        if (HAS_PAD) begin st_d = ST_WPAD; t_load = 1'b1; t_val = LD_PAD; end
        else st_d = ST_IDLE;
      end
      ST_WPAD: if (t_zero) st_d = ST_IDLE;
      ST_RACC: if (t_zero) begin
        st_d = ST_RTAIL; t_load = 1'b1; t_val = LD_RT; capture = 1'b1;
      end
      ST_RTAIL: if (t_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign idle   = (st_q == ST_IDLE);
  assign drv    = (st_q == ST_WSETUP) || (st_q == ST_WPULSE) || (st_q == ST_WHOLD);
  assign we_act = (st_q == ST_WPULSE);
  assign oe_act = (st_q == ST_RACC);
  assign sel    = drv || oe_act;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_WC_NS = 70,
  parameter int unsigned T_WP_NS = 50,
  parameter int unsigned T_CW_NS = 60,
  parameter int unsigned T_AW_NS = 60,
  parameter int unsigned T_DW_NS = 25,
  parameter int unsigned T_RC_NS = 70,
  parameter int unsigned T_AA_NS = 70,
  parameter int unsigned T_CO_NS = 70,
  parameter int unsigned T_OE_NS = 35,
  parameter int unsigned T_HZ_NS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_cs,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int unsigned WPL   = wr_pulse(T_WP_NS, T_DW_NS, T_CW_NS, T_AW_NS, CLK_NS);
  localparam int unsigned WPAD  = wr_pad(T_WC_NS, WPL, CLK_NS);
  localparam int unsigned ACC   = rd_access(T_AA_NS, T_CO_NS, T_OE_NS, CLK_NS);
  localparam int unsigned RT    = rd_tail(T_HZ_NS, T_RC_NS, ACC, CLK_NS);
  localparam int unsigned CMAX  = imax(imax(WPL, WPAD), imax(ACC, RT));
  localparam int unsigned CNT_W = imax($clog2(CMAX + 1), 1);

  logic accept, capture;
  logic idle, sel, oe_act, we_act, drv;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign accept = req_valid && idle;

  asram_seq #(
    .WPL(WPL), .WPAD(WPAD), .ACC(ACC), .RT(RT), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_wr(req_write),
    .idle(idle), .sel(sel), .oe_act(oe_act), .we_act(we_act), .drv(drv),
    .capture(capture)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= sram_dq_in;
    end
  end

  assign req_ready   = idle;
  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;
  assign sram_dq_oe  = drv;
  assign sram_cs_n   = !sel;
  assign sram_cs     = sel;
  assign sram_oe_n   = !oe_act;
  assign sram_we_n   = !we_act;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              capture,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_cs_n,
  input logic              sram_cs,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe
);
  always_comb begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (sram_cs_n && !sram_cs && sram_oe_n && sram_we_n && !sram_dq_oe); // R1
    end
  end

  AST_SEL_PAIR: assert property (@(posedge clk) disable iff (!rst_n) sram_cs_n == !sram_cs); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (sram_cs_n && !sram_dq_oe)); // R2
  AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $fell(sram_we_n) |-> $past(!sram_cs_n && sram_dq_oe && sram_we_n)); // R3
  AST_WE_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n) $rose(sram_we_n) |-> (!sram_cs_n && sram_dq_oe)); // R4
  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !sram_we_n |-> ($stable(sram_addr) && $stable(sram_dq_out))); // R4
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) accept |=> !req_ready); // R5
  AST_RDV_FOLLOWS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) capture |=> rd_valid); // R6
  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R6
  AST_TAIL_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) $rose(sram_oe_n) |-> (!req_ready && sram_cs_n)); // R7
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!sram_oe_n && !sram_we_n)); // R8
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) !sram_oe_n |-> !sram_dq_oe); // R8
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
  .req_ready(req_ready), .rd_valid(rd_valid), .sram_addr(sram_addr),
  .sram_dq_out(sram_dq_out), .sram_cs_n(sram_cs_n), .sram_cs(sram_cs),
  .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq_oe(sram_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;
  localparam int CLK = 20;
  localparam int WC = 140, WP = 50, CW = 60, AW = 60, DW = 25;
  localparam int RC = 140, AA = 70, CO = 70, OE = 35, HZ = 25;

  function automatic int up(input int ns);
    return ns / CLK + ((ns % CLK) != 0 ? 1 : 0);
  endfunction
  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction

  localparam int E_WPL   = mx(mx(mx(up(WP), up(DW)), mx(up(CW) - 1, up(AW) - 1)), 1);
  localparam int E_WBUSY = mx(E_WPL + 2, up(WC));
  localparam int E_ACC   = mx(mx(up(AA), up(CO)), up(OE));
  localparam int E_RBUSY = E_ACC + mx(mx(up(HZ), up(RC) - E_ACC), 1);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, sram_cs_n, sram_cs, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0] rd_data, sram_dq_out, sram_dq_in;
  logic [16:0] sram_addr;

  int checks = 0, failures = 0;

  always #(CLK / 2) clk = ~clk;

  asram_ctrl #(
    .CLK_NS(CLK), .T_WC_NS(WC), .T_WP_NS(WP), .T_CW_NS(CW), .T_AW_NS(AW), .T_DW_NS(DW),
    .T_RC_NS(RC), .T_AA_NS(AA), .T_CO_NS(CO), .T_OE_NS(OE), .T_HZ_NS(HZ)
  ) u_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_cs(sram_cs), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural memory with pin-level timing checks (time measured at negedges)
  logic [7:0] mem [logic [16:0]];
  logic [7:0] mdq = 8'h00;
  int sel_c = 0, adr_c = 0, ds_c = 0, wp_c = 0, acc_c = 0, rel = 15;
  logic p_wact = 0, p_oe = 0;
  logic [16:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  assign sram_dq_in = mdq;

  always @(negedge clk) begin
    logic sel, wact, rdrv;
    if (rst_n) begin
      sel  = !sram_cs_n && sram_cs;
      wact = sel && !sram_we_n;
      rdrv = sel && !sram_oe_n && sram_we_n;
      if (p_wact && !wact) begin
        chk(wp_c * CLK >= WP, "R3 write pulse ns", wp_c * CLK, WP);
        chk(ds_c * CLK >= DW, "R3 data setup ns", ds_c * CLK, DW);
        chk(sel_c * CLK >= CW, "R3 select to end ns", sel_c * CLK, CW);
        chk(adr_c * CLK >= AW, "R3 address to end ns", adr_c * CLK, AW);
        chk(sram_dq_oe && sram_dq_out == p_dq && sel, "R4 hold after write", sram_dq_out, p_dq);
        mem[p_addr] = p_dq;
      end
      if (sram_dq_oe && !p_oe)
        chk(!rdrv && (rel * CLK - CLK) >= HZ, "R7 float window", rel, 3);
      sel_c = sel ? sel_c + 1 : 0;
      adr_c = (sram_addr == p_addr) ? adr_c + 1 : 1;
      ds_c  = sram_dq_oe ? ((p_oe && sram_dq_out == p_dq) ? ds_c + 1 : 1) : 0;
      wp_c  = wact ? wp_c + 1 : 0;
      acc_c = rdrv ? ((sram_addr == p_addr) ? acc_c + 1 : 1) : 0;
      rel   = rdrv ? 0 : (rel < 15 ? rel + 1 : 15);
      if (rdrv) mdq <= ((acc_c * CLK - CLK / 2) >= AA) ?
                       (mem.exists(sram_addr) ? mem[sram_addr] : 8'h00) : 8'hEE;
      else      mdq <= 8'h00;
      p_wact = wact; p_oe = sram_dq_oe; p_addr = sram_addr; p_dq = sram_dq_out;
    end
  end

  // width of the last write-enable low pulse
  int we_run = 0, last_wp = 0;
  always @(negedge clk) begin
    if (!sram_we_n) we_run++;
    else if (we_run > 0) begin last_wp = we_run; we_run = 0; end
  end

  task automatic op(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int busy, k, rdv_at, rdv_n;
    logic [7:0] got;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~d;
    busy = 0; k = 1; rdv_at = 0; rdv_n = 0; got = '0;
    while (!req_ready) begin
      if (rd_valid) begin rdv_at = k; rdv_n++; got = rd_data; end
      busy++; k++;
      @(negedge clk);
    end
    if (rd_valid) rdv_n++;
    chk(sram_cs_n && sram_cs == 0 && !sram_dq_oe, "R2 idle deselected", {sram_cs_n, sram_cs, sram_dq_oe}, 3'b100);
    if (wr) begin
      chk(busy == E_WBUSY, "R5 write busy cycles", busy, E_WBUSY);
      chk(last_wp == E_WPL, "R3 write enable low cycles", last_wp, E_WPL);
      chk(rdv_n == 0, "R6 no read strobe on write", rdv_n, 0);
    end else begin
      chk(busy == E_RBUSY, "R7 read busy cycles", busy, E_RBUSY);
      chk(rdv_n == 1 && rdv_at == E_ACC + 1, "R6 read strobe cycle", rdv_at, E_ACC + 1);
      chk(got == d, "R4 R6 read data", got, d);
    end
  endtask

  // {write, address, data-or-expected}
  localparam logic [25:0] VEC [10] = '{
    {1'b1, 17'h00000, 8'h3C}, {1'b1, 17'h1FFFF, 8'hC3}, {1'b1, 17'h0ABCD, 8'h5A},
    {1'b0, 17'h1FFFF, 8'hC3}, {1'b0, 17'h00000, 8'h3C}, {1'b1, 17'h0ABCD, 8'hA5},
    {1'b0, 17'h0ABCD, 8'hA5}, {1'b0, 17'h0ABCD, 8'hA5}, {1'b1, 17'h10001, 8'hFF},
    {1'b0, 17'h10001, 8'hFF}
  };

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sram_cs_n && !sram_cs && sram_oe_n && sram_we_n && !sram_dq_oe, "R1 pins in reset",
        {sram_cs_n, sram_cs, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rd_valid, "R1 ready after reset", {req_ready, rd_valid}, 2'b10);
    chk(sram_cs_n && !sram_cs && sram_oe_n && sram_we_n && !sram_dq_oe, "R1 pins after reset",
        {sram_cs_n, sram_cs, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);

    for (int i = 0; i < 10; i++) op(VEC[i][25], VEC[i][24:8], VEC[i][7:0]);

    // read immediately followed by write: turnaround, then readback
    op(1'b0, 17'h00000, 8'h3C);
    op(1'b1, 17'h00000, 8'h81);
    op(1'b0, 17'h00000, 8'h81);

    // idle with no request: bus stays quiet (R2, R8)
    repeat (5) @(negedge clk);
    chk(sram_oe_n && sram_we_n && !sram_dq_oe && !rd_valid, "R8 quiet idle",
        {sram_oe_n, sram_we_n, sram_dq_oe, rd_valid}, 4'b1100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule